// File: doc/BRIEF.md
# Host-Mapped Message Block Mover

This block is the host-facing half of a dual-redundant serial bus terminal. A host processor reaches it through plain I/O cycles: a 4-bit address, an active-low device select, active-low read and write strobes, and a 16-bit data bus. Here the data bus appears as a read-data output with an output-enable, so the tri-state driver can sit at the chip pad. Inside the block are a 16-bit control register, a 32-word staging FIFO filled by the host, a 32-word return FIFO drained by the host, and a 2048-word message store. The store is split into a transmit half and a receive half of 32 blocks each, and each block holds 32 words.

The host picks a block and a direction in the control register, then writes an execute code. The copy engine then moves the words. In the fill direction it copies whatever the staging FIFO holds (1 to 32 words) into the block. In the drain direction it copies all 32 words of the block into the return FIFO. Each word takes three clocks. When the copy ends, an active-low completion strobe lasts one clock. A ready level tells the host that the return FIFO holds data, so the host can start reading before the copy has finished. A second execute code keeps the staging contents after the fill, so the same data can be stored into several blocks without writing it again.

Top module: `blk_mover`

## Requirements
- R1: While `host_sel_n` is high, strobes have no effect: the control register does not change, and `host_rdata_oe` stays low.
- R2: After reset the control register reads 16'hFF80. A write to address 4'h0 replaces all 16 bits, and a read of 4'h0 returns them. Bits [4:0] are the block number, bit 5 selects the half (1 = transmit), and bit 6 is the direction (1 = staging FIFO to store, 0 = store to return FIFO).
- R3: Writes to address 4'hE append to the staging FIFO. The first 32 are kept, and further writes are dropped.
- R4: Writing 4'h8 with bit 6 set copies the N staged words, in order, to store addresses {bit5, bits[4:0], index}. `done_n` is low for exactly one clock, in the 3N-th clock after the write strobe rises.
- R5: A fill execute issued while the staging FIFO is empty copies nothing and gives no `done_n` pulse.
- R6: A drain execute (bit 6 clear) first empties the return FIFO. It then loads all 32 words of the block in index order, and `done_n` pulses in the 96th clock.
- R7: A fill started with code 4'hA leaves the staging FIFO intact afterwards. A fill started with code 4'h8 leaves it empty.
- R8: `obuf_ready` is low after reset. It rises when the first word enters the return FIFO, and it falls when that FIFO is cleared or read empty.
- R9: Code 4'hB clears the staging FIFO, 4'hD clears the return FIFO, and 4'hC clears both.
- R10: While a copy runs, writes to the control register and the staging FIFO, executes and clears are all ignored.
- R11: Each read of 4'hE returns the oldest return-FIFO word and removes it. This works during a running drain as soon as `obuf_ready` is high.
- R12: The two halves are separate: the same block number in each half keeps its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low master reset |
| host_sel_n | input | 1 | Device select, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| host_wr_n | input | 1 | Write strobe, active low; acts on its rising edge |
| host_addr | input | 4 | Register or command code |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_rdata_oe | output | 1 | Drive enable for the host data pins |
| done_n | output | 1 | One-clock active-low copy-complete strobe |
| obuf_ready | output | 1 | High while the return FIFO holds data |

## Verification
The hardest case to reach is a host read that overlaps a running drain. The word has to be taken from the return FIFO in the same few clocks in which the engine pushes the next ones, and the clear at the start of the drain must already have taken effect. The stimulus reaches this case by polling `obuf_ready` straight after the drain execute and issuing the read at once, while the copy still has about ninety clocks to run. It then checks that the remaining 31 words arrive in order after `done_n`. The random part draws a half, a block and a fill length, and randomly chooses whether the fill keeps its staged words. A chosen keep is followed by a plain fill into a neighbouring block and by a fill that must find the staging FIFO empty.

// File: rtl/mover_pkg.sv
package mover_pkg;
  localparam logic [15:0] OP_RESET = 16'hFF80;

  typedef enum logic [3:0] {
    ADR_OPREG    = 4'h0,
    ADR_EXEC     = 4'h8,
    ADR_EXEC_RPT = 4'hA,
    ADR_CLR_IN   = 4'hB,
    ADR_CLR_ALL  = 4'hC,
    ADR_CLR_OUT  = 4'hD,
    ADR_DATA     = 4'hE
  } host_adr_e;

  typedef struct packed {
    logic op_wr;
    logic data_wr;
    logic exec;
    logic exec_rpt;
    logic clr_in;
    logic clr_out;
    logic clr_all;
    logic data_rd;
  } host_ev_t;
endpackage

// File: rtl/host_decode.sv
module host_decode
  import mover_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [3:0] addr,
  output host_ev_t   ev
);
  logic rd_q, wr_q;
  logic wr_rise, rd_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b1;
      wr_q <= 1'b1;
    end else begin
      rd_q <= rd_n;
      wr_q <= wr_n;
    end
  end

  assign wr_rise = !sel_n && wr_n && !wr_q;
  assign rd_rise = !sel_n && rd_n && !rd_q;

  always_comb begin
    ev          = '0;
    ev.op_wr    = wr_rise && (addr == ADR_OPREG);
    ev.data_wr  = wr_rise && (addr == ADR_DATA);
    ev.exec     = wr_rise && (addr == ADR_EXEC);
    ev.exec_rpt = wr_rise && (addr == ADR_EXEC_RPT);
    ev.clr_in   = wr_rise && (addr == ADR_CLR_IN);
    ev.clr_out  = wr_rise && (addr == ADR_CLR_OUT);
    ev.clr_all  = wr_rise && (addr == ADR_CLR_ALL);
    ev.data_rd  = rd_rise && (addr == ADR_DATA);
  end

  // R1: host never drives both strobes during a selected cycle
  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_n |-> (rd_n || wr_n));
  // R9: at most one command event per edge
  assert_one_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev));
endmodule

// File: rtl/word_fifo.sv
module word_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  input  logic [PW-1:0] peek_off,
  output logic [DW-1:0] peek_data,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          full, empty, push_ok, pop_ok;
  logic [PW-1:0] peek_idx;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign peek_idx = rptr + peek_off;
  assign peek_data = mem[peek_idx];

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end

  // R3: producers only push into a FIFO with room
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clr) |-> !full);
  // R11: consumers only pop a FIFO holding data
  assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> !empty);
endmodule

// File: rtl/msg_ram.sv
module msg_ram #(
  parameter int DW = 16,
  parameter int AW = 11,
  localparam int WORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/copy_engine.sv
module copy_engine #(
  parameter int DW    = 16,
  parameter int SA_W  = 5,
  parameter int IDX_W = 5,
  localparam int AW   = 1 + SA_W + IDX_W,
  localparam int CW   = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_rpt,
  input  logic [SA_W-1:0]  op_sa,
  input  logic             op_tr,
  input  logic             op_load,
  input  logic [CW-1:0]    in_count,
  input  logic [DW-1:0]    in_data,
  input  logic [DW-1:0]    ram_rdata,
  output logic             busy,
  output logic [IDX_W-1:0] in_peek_off,
  output logic             in_clr,
  output logic             out_clr,
  output logic             out_push,
  output logic [DW-1:0]    out_wdata,
  output logic             ram_we,
  output logic [AW-1:0]    ram_addr,
  output logic [DW-1:0]    ram_wdata,
  output logic             done_q
);
  function automatic logic [AW-1:0] blk_addr(input logic tr,
                                             input logic [SA_W-1:0] sa,
                                             input logic [IDX_W-1:0] ix);
    return {tr, sa, ix};
  endfunction

  logic             load_q, rpt_q, tr_q;
  logic [SA_W-1:0]  sa_q;
  logic [IDX_W-1:0] last_q, idx;
  logic [1:0]       ph;
  logic [CW-1:0]    cnt_m1;
  logic             start_ok, step, finishing;

  assign cnt_m1    = in_count - CW'(1);
  assign start_ok  = (go || go_rpt) && !busy && (!op_load || in_count != '0);
  assign step      = busy && (ph == 2'd2);
  assign finishing = step && (idx == last_q);

  assign in_peek_off = idx;
  assign ram_addr    = blk_addr(tr_q, sa_q, idx);
  assign ram_we      = step && load_q;
  assign ram_wdata   = in_data;
  assign out_push    = step && !load_q;
  assign out_wdata   = ram_rdata;
  assign out_clr     = start_ok && !op_load;
  assign in_clr      = finishing && load_q && !rpt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      load_q <= 1'b0;
      rpt_q  <= 1'b0;
      tr_q   <= 1'b0;
      sa_q   <= '0;
      last_q <= '0;
      idx    <= '0;
      ph     <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finishing;
      if (start_ok) begin
        busy   <= 1'b1;
        load_q <= op_load;
        rpt_q  <= go_rpt;
        tr_q   <= op_tr;
        sa_q   <= op_sa;
        last_q <= op_load ? cnt_m1[IDX_W-1:0] : '1;
        idx    <= '0;
        ph     <= '0;
      end else if (busy) begin
        if (step) begin
          ph  <= '0;
          idx <= idx + 1'b1;
          if (finishing) busy <= 1'b0;
        end else begin
          ph <= ph + 1'b1;
        end
      end
    end
  end

  // R4: completion strobe lasts a single clock
  assert_done_one_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R4: completion only ends a running copy
  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(busy));
  // R10: a running copy keeps its target while it runs
  assert_target_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finishing) |=> ($stable(sa_q) && $stable(tr_q) && $stable(load_q)));
endmodule

// File: rtl/blk_mover.sv
module blk_mover
  import mover_pkg::*;
#(
  parameter int DW    = 16,
  parameter int SA_W  = 5,
  parameter int IDX_W = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_sel_n,
  input  logic          host_rd_n,
  input  logic          host_wr_n,
  input  logic [3:0]    host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rdata_oe,
  output logic          done_n,
  output logic          obuf_ready
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int AW    = 1 + SA_W + IDX_W;
  localparam int CW    = IDX_W + 1;

  host_ev_t         ev;
  logic [DW-1:0]    opreg;
  logic             busy, done_q;
  logic [CW-1:0]    in_count, out_count;
  logic [DW-1:0]    in_peek, out_peek;
  logic [IDX_W-1:0] in_off;
  logic             eng_in_clr, eng_out_clr, out_push, ram_we;
  logic [DW-1:0]    out_wdata, ram_wdata, ram_rdata;
  logic [AW-1:0]    ram_addr;
  logic             in_push, in_clr, out_clr, out_pop;

  host_decode u_dec (
    .clk(clk), .rst_n(rst_n), .sel_n(host_sel_n), .rd_n(host_rd_n),
    .wr_n(host_wr_n), .addr(host_addr), .ev(ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                opreg <= OP_RESET;
    else if (ev.op_wr && !busy) opreg <= host_wdata;
  end

  assign in_push = ev.data_wr && !busy && (in_count != CW'(DEPTH));
  assign in_clr  = eng_in_clr || (!busy && (ev.clr_in || ev.clr_all));
  assign out_clr = eng_out_clr || (!busy && (ev.clr_out || ev.clr_all));
  assign out_pop = ev.data_rd && (out_count != '0);

  word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_infifo (
    .clk(clk), .rst_n(rst_n), .clr(in_clr), .push(in_push),
    .wdata(host_wdata), .pop(1'b0), .peek_off(in_off),
    .peek_data(in_peek), .count(in_count)
  );

  word_fifo #(.DW(DW), .DEPTH(DEPTH)) u_outfifo (
    .clk(clk), .rst_n(rst_n), .clr(out_clr), .push(out_push),
    .wdata(out_wdata), .pop(out_pop), .peek_off('0),
    .peek_data(out_peek), .count(out_count)
  );

  msg_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_addr), .wdata(ram_wdata),
    .raddr(ram_addr), .rdata(ram_rdata)
  );

  copy_engine #(.DW(DW), .SA_W(SA_W), .IDX_W(IDX_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .go(ev.exec && !busy), .go_rpt(ev.exec_rpt && !busy),
    .op_sa(opreg[SA_W-1:0]), .op_tr(opreg[SA_W]), .op_load(opreg[SA_W+1]),
    .in_count(in_count), .in_data(in_peek), .ram_rdata(ram_rdata),
    .busy(busy), .in_peek_off(in_off), .in_clr(eng_in_clr),
    .out_clr(eng_out_clr), .out_push(out_push), .out_wdata(out_wdata),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .done_q(done_q)
  );

  always_comb begin
    host_rdata = '0;
    if (host_addr == ADR_OPREG)                          host_rdata = opreg;
    else if (host_addr == ADR_DATA && out_count != '0)   host_rdata = out_peek;
  end

  assign host_rdata_oe = !host_sel_n && !host_rd_n;
  assign done_n        = !done_q;
  assign obuf_ready    = (out_count != '0);

  // R8: ready level only rises when the engine has pushed a word
  assert_flag_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(obuf_ready) |-> $past(out_push));
  // R10: control register frozen during a copy
  assert_busy_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(opreg));
  // R1: deselected cycles leave the control register alone
  assert_desel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    host_sel_n |=> $stable(opreg));
endmodule

// File: tb/sim_blk_mover.sv
module sim_blk_mover;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        oe, done_n, ready;

  int nchk = 0, nerr = 0;
  bit finished = 0;

  logic [15:0] mdl [0:2047];
  bit          mval [0:2047];
  logic [15:0] inq [0:31];
  int          incnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_mover u0 (
    .clk(clk), .rst_n(rst_n), .host_sel_n(sel_n), .host_rd_n(rd_n),
    .host_wr_n(wr_n), .host_addr(addr), .host_wdata(wdata),
    .host_rdata(rdata), .host_rdata_oe(oe), .done_n(done_n), .obuf_ready(ready)
  );

  function automatic int maddr(input logic tr, input logic [4:0] sa, input int ix);
    return (int'(tr) << 10) + (int'(sa) << 5) + ix;
  endfunction

  function automatic logic [15:0] opval(input bit ld, input logic tr, input logic [4:0] sa);
    return 16'hFF80 | (16'(ld) << 6) | (16'(tr) << 5) | 16'(sa);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); sel_n = 0; addr = a; wdata = d; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk); sel_n = 1;
  endtask

  task automatic hr(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); sel_n = 0; addr = a; rd_n = 0;
    @(negedge clk); d = rdata; rd_n = 1;
    @(negedge clk); sel_n = 1;
  endtask

  task automatic wait_done(input int lim, output int cyc);
    cyc = 0;
    for (int c = 1; c <= lim; c++) begin
      @(negedge clk);
      if (!done_n) begin cyc = c; return; end
    end
  endtask

  task automatic stage(input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] d = 16'($urandom);
      hw(4'hE, d);
      if (incnt < 32) begin inq[incnt] = d; incnt++; end
    end
  endtask

  // fill execute with exact cycle check and model update
  task automatic fill(input logic tr, input logic [4:0] sa, input bit rpt, input string tag);
    int cyc;
    hw(4'h0, opval(1, tr, sa));
    hw(rpt ? 4'hA : 4'h8, 16'h0);
    wait_done(200, cyc);
    if (incnt == 0) chk(cyc == 0, tag, cyc, 0);
    else begin
      chk(cyc == 3*incnt, tag, cyc, 3*incnt);
      for (int i = 0; i < incnt; i++) begin
        mdl[maddr(tr, sa, i)] = inq[i];
        mval[maddr(tr, sa, i)] = 1;
      end
      if (!rpt) incnt = 0;
    end
  endtask

  task automatic drain(input logic tr, input logic [4:0] sa, input bit early, input string tag);
    int cyc, first;
    logic [15:0] d;
    hw(4'h0, opval(0, tr, sa));
    hw(4'h8, 16'h0);
    first = 0;
    if (early) begin
      for (int k = 0; k < 20 && !ready; k++) @(negedge clk);
      hr(4'hE, d);  // R11 read during a running drain
      chk(!mval[maddr(tr, sa, 0)] || d == mdl[maddr(tr, sa, 0)], "R11", d, mdl[maddr(tr, sa, 0)]);
      first = 1;
      wait_done(200, cyc);
      chk(cyc != 0, "R6", cyc, 1);
    end else begin
      wait_done(200, cyc);
      chk(cyc == 96, tag, cyc, 96);
      chk(ready == 1, "R8", ready, 1);
    end
    for (int i = first; i < 32; i++) begin
      hr(4'hE, d);
      if (mval[maddr(tr, sa, i)])
        chk(d == mdl[maddr(tr, sa, i)], tag, d, mdl[maddr(tr, sa, i)]);
    end
    chk(ready == 0, "R8", ready, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int cyc;
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) mval[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 reset values
    hr(4'h0, d);
    chk(d == 16'hFF80, "R2", d, 16'hFF80);
    chk(done_n == 1, "R4", done_n, 1);
    chk(ready == 0, "R8", ready, 0);

    // R1 deselected write and read
    @(negedge clk); addr = 4'h0; wdata = 16'h1234; wr_n = 0;
    @(negedge clk); wr_n = 1;
    @(negedge clk); rd_n = 0;
    @(negedge clk); chk(oe == 0, "R1", oe, 0); rd_n = 1;
    hr(4'h0, d);
    chk(d == 16'hFF80, "R1", d, 16'hFF80);
    chk(oe == 0, "R1", oe, 0);

    // R2 write/readback
    hw(4'h0, 16'h5AA5);
    hr(4'h0, d);
    chk(d == 16'h5AA5, "R2", d, 16'h5AA5);

    // R5 empty fill
    hw(4'h0, opval(1, 0, 5'd3));
    hw(4'h8, 16'h0);
    wait_done(100, cyc);
    chk(cyc == 0, "R5", cyc, 0);

    // R3 overfill, R4 full block into top block, R6/R11 early drain
    stage(33);
    fill(1, 5'd31, 0, "R4");
    drain(1, 5'd31, 1, "R6");

    // R7 repeat keeps staged words, R12 halves separate
    stage(5);
    fill(0, 5'd0, 1, "R7");
    fill(1, 5'd0, 0, "R7");
    fill(1, 5'd1, 0, "R7");  // staging now empty: no pulse
    stage(4);
    fill(1, 5'd0, 0, "R12");
    drain(0, 5'd0, 0, "R12");
    drain(1, 5'd0, 0, "R6");

    // R10 writes during a copy are ignored
    hw(4'h0, opval(0, 1, 5'd31));
    hw(4'h8, 16'h0);
    hw(4'h0, 16'h0042);
    hw(4'hE, 16'hBEEF);
    wait_done(200, cyc);
    chk(cyc != 0, "R10", cyc, 1);
    hr(4'h0, d);
    chk(d == opval(0, 1, 5'd31), "R10", d, opval(0, 1, 5'd31));
    hw(4'hD, 16'h0);  // R9 clear return FIFO
    chk(ready == 0, "R9", ready, 0);
    hw(4'h0, opval(1, 0, 5'd9));
    hw(4'h8, 16'h0);
    wait_done(100, cyc);
    chk(cyc == 0, "R10", cyc, 0);

    // R9 staging clear and clear-all
    stage(3);
    hw(4'hB, 16'h0); incnt = 0;
    fill(0, 5'd9, 0, "R9");
    drain(0, 5'd2, 0, "R6");
    hw(4'h0, opval(0, 0, 5'd2));
    hw(4'h8, 16'h0);
    wait_done(200, cyc);
    stage(2);
    hw(4'hC, 16'h0); incnt = 0;
    chk(ready == 0, "R9", ready, 0);
    fill(0, 5'd9, 0, "R9");

    // random mix
    for (int it = 0; it < 10; it++) begin
      logic       tr = 1'($urandom);
      logic [4:0] sa = 5'($urandom);
      int         n  = 1 + int'($urandom % 32);
      bit         rp = 1'($urandom);
      stage(n);
      fill(tr, sa, rp, rp ? "R7" : "R4");
      if (rp) begin
        fill(tr, sa ^ 5'd1, 0, "R7");
        fill(tr, sa ^ 5'd2, 0, "R5");
        drain(tr, sa ^ 5'd1, 0, "R6");
      end
      drain(tr, sa, it[0], "R6");
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule